// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes a 16-bit CPU from normal execution into an interrupt handler. It watches for a request from the priority arbiter. It takes the request at an instruction boundary. It can also take the request in the middle of a long repeat-type instruction (block move, string store, repeated multiply-accumulate). In that case it raises a flag so the core keeps the partial state of that instruction. A software interrupt instruction can also start the sequence, with its own vector number.

Once started, the sequencer holds the core stalled and acts as bus master for a fixed series of accesses:

1. An acknowledge read that returns the source number and its priority level.
2. A push of a word holding the pre-entry flags.
3. A push of the low half of the return address.
4. Two reads of the vector table.

At the end it writes the new flag word, stack pointer and program counter to the core in one cycle.

The state machine has eight states: IDLE, ACK, SAVE, PUSHF, PUSHP, VLO, VHI and COMMIT.
- IDLE→ACK on a qualified request.
- ACK→SAVE on bus ready.
- SAVE→PUSHF always.
- PUSHF→PUSHP, PUSHP→VLO, VLO→VHI and VHI→COMMIT on bus ready.
- COMMIT→IDLE once the busy-cycle counter reaches its last value.

Top module: `irq_entry_seq`

## Requirements
- R1: With `swi_req` low, a hardware request (`irq_pending`) is taken only in a cycle where `at_boundary` or `long_op` is high. `busy` rises on the next cycle. A request without either qualifier leaves `busy` and `bus_req` low.
- R2: `suspended` is high for the whole sequence when a hardware request was taken with `at_boundary` low and `long_op` high. It stays low for boundary entries and software entries.
- R3: The first bus access is a read of address 0. In its data, bits [5:0] are the source number and bits [14:12] are the priority level.
- R4: For a hardware entry, `irq_clr` pulses high for exactly one cycle after the acknowledge read, with `irq_clr_num` equal to the acknowledged number. A software entry never pulses it.
- R5: Let B be the selected stack pointer.
  - The second access writes address B-2. Its data is the pre-entry flag word, with bits [11:8] replaced by PC bits [19:16].
  - The third access writes address B-4 with PC bits [15:0].
- R6: The fourth and fifth accesses read `VEC_BASE + 4*n` and `VEC_BASE + 4*n + 2`, where n is the entry's vector number.
- R7: The new flag word clears interrupt enable (bit 6) and single-step (bit 1). All other bits are kept, except those named in R8 and R9.
- R8: The stack-select bit (bit 7) is cleared. The exception is a software entry with vector number 32 to 63: there the bit keeps its value. If the bit was 1 in that case, the user stack pointer is used (`sp_sel`=1); otherwise the interrupt stack pointer is used.
- R9: For a hardware entry, the level field (bits [14:12]) is loaded with the acknowledged level. For a software entry it is left unchanged.
- R10: `pc_we` pulses exactly once per entry, with `pc_wdata` = {bits [3:0] of the vec+2 read, the 16-bit vec read}. `busy` falls on the next cycle.
- R11: `sp_we` pulses with `pc_we`, with `sp_wdata` = B-4.
- R12: With zero-wait bus responses, `busy` lasts exactly 18 cycles. Each access holds `bus_req`, `bus_addr` and `bus_we` until `bus_rdy`. When waits push the last access past the 17th busy cycle, commit follows one cycle after it.
- R13: When `swi_req` and a qualified hardware request arrive in the same cycle, the software entry is taken and `irq_clr` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pending | input | 1 | Arbiter has a hardware request waiting |
| at_boundary | input | 1 | Current instruction completes this cycle |
| long_op | input | 1 | A suspendable repeat-type instruction is executing |
| swi_req | input | 1 | Software interrupt instruction requests entry |
| swi_num | input | 6 | Vector number of the software interrupt |
| flg_in | input | 16 | Current flag register |
| pc_in | input | 20 | Return address |
| isp_in | input | 16 | Interrupt stack pointer |
| usp_in | input | 16 | User stack pointer |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 20 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdy | input | 1 | Access completes this cycle |
| bus_rdata | input | 16 | Read data |
| busy | output | 1 | Sequence in progress; core stalls |
| suspended | output | 1 | Entry interrupted a repeat-type instruction |
| irq_clr | output | 1 | Clear the pending bit of the acknowledged source |
| irq_clr_num | output | 6 | Source number to clear |
| flg_we | output | 1 | Flag register write |
| flg_wdata | output | 16 | New flag value |
| sp_we | output | 1 | Stack pointer write |
| sp_sel | output | 1 | 1 = user stack pointer, 0 = interrupt stack pointer |
| sp_wdata | output | 16 | New stack pointer |
| pc_we | output | 1 | Program counter write |
| pc_wdata | output | 20 | Handler start address |

## Verification
The hardest case to reach is the stretched timing of R12. The busy count is fixed only while bus waits are short. Once waits push the last vector read past the counter's final value, the commit must come right after that read. This is reached by a bus responder in the bench that inserts a chosen number of wait cycles on every access; three waits per access lands beyond the 18-cycle frame. The other hard corners are the stack-select boundary at vector numbers 31 and 32, and a simultaneous hardware and software request. Both are reached by driving the request inputs in a single cycle with chosen flag values.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // Sequencer states, in bus order
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_SAVE,
        ST_PUSHF,
        ST_PUSHP,
        ST_VLO,
        ST_VHI,
        ST_COMMIT
    } entry_state_t;

    // Vector number and priority level widths
    localparam int unsigned NUM_W       = 6;
    localparam int unsigned LVL_W       = 3;

    // Acknowledge word layout
    localparam int unsigned ACK_NUM_LSB = 0;
    localparam int unsigned ACK_LVL_LSB = 12;

    // Flag word layout
    localparam int unsigned FLG_D       = 1;
    localparam int unsigned FLG_I       = 6;
    localparam int unsigned FLG_U       = 7;
    localparam int unsigned PCHI_LSB    = 8;
    localparam int unsigned IPL_LSB     = 12;

    // Software numbers at or above this keep the stack-select bit
    localparam int unsigned SWI_KEEP_MIN = 32;

endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int unsigned ENTRY_CYCLES = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         bus_rdy,
    output entry_state_t state,
    output logic         busy,
    output logic         bus_req,
    output logic         bus_we,
    output logic         step_done,
    output logic         commit
);
    localparam int unsigned CW   = $clog2(ENTRY_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(ENTRY_CYCLES - 1);

    entry_state_t  nxt;
    logic [CW-1:0] cyc;

    // State register and saturating busy-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cyc   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                cyc <= '0;
            end else if (cyc != LAST) begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go)        nxt = ST_ACK;
            ST_ACK:    if (bus_rdy)   nxt = ST_SAVE;
            ST_SAVE:                  nxt = ST_PUSHF;
            ST_PUSHF:  if (bus_rdy)   nxt = ST_PUSHP;
            ST_PUSHP:  if (bus_rdy)   nxt = ST_VLO;
            ST_VLO:    if (bus_rdy)   nxt = ST_VHI;
            ST_VHI:    if (bus_rdy)   nxt = ST_COMMIT;
            ST_COMMIT: if (cyc == LAST) nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // Control outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        bus_req = 1'b0;
        bus_we  = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_ACK, ST_VLO, ST_VHI: bus_req = 1'b1;
            ST_PUSHF, ST_PUSHP: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            ST_COMMIT: commit = (cyc == LAST);
            default: ;
        endcase
        step_done = bus_req & bus_rdy;
    end

endmodule

// File: rtl/irq_entry_addr.sv
module irq_entry_addr
    import irq_entry_pkg::*;
#(
    parameter int unsigned   AW       = 20,
    parameter int unsigned   DW       = 16,
    parameter logic [AW-1:0] VEC_BASE = 20'hFFD00
) (
    input  entry_state_t     state,
    input  logic [DW-1:0]    sp_base,
    input  logic [NUM_W-1:0] vec_num,
    input  logic [DW-1:0]    save_word,
    input  logic [DW-1:0]    pc_lo,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata
);
    logic [AW-1:0] vec_addr;

    always_comb begin
        vec_addr = VEC_BASE + (AW'(vec_num) << 2);
    end

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_ACK:   bus_addr = '0;
            ST_PUSHF: begin
                bus_addr  = AW'(sp_base - DW'(2));
                bus_wdata = save_word;
            end
            ST_PUSHP: begin
                bus_addr  = AW'(sp_base - DW'(4));
                bus_wdata = pc_lo;
            end
            ST_VLO:   bus_addr = vec_addr;
            ST_VHI:   bus_addr = vec_addr + AW'(2);
            default:  ;
        endcase
    end

endmodule

// File: rtl/irq_entry_flags.sv
module irq_entry_flags
    import irq_entry_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0]    flg_copy,
    input  logic             is_swi,
    input  logic [NUM_W-1:0] num,
    input  logic [LVL_W-1:0] level,
    output logic [DW-1:0]    flg_new
);
    logic keep_u;

    always_comb begin
        keep_u         = is_swi && (num >= NUM_W'(SWI_KEEP_MIN));
        flg_new        = flg_copy;
        flg_new[FLG_I] = 1'b0;
        flg_new[FLG_D] = 1'b0;
        if (!keep_u) begin
            flg_new[FLG_U] = 1'b0;
        end
        if (!is_swi) begin
            flg_new[IPL_LSB +: LVL_W] = level;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned   AW           = 20,
    parameter int unsigned   DW           = 16,
    parameter int unsigned   ENTRY_CYCLES = 18,
    parameter logic [AW-1:0] VEC_BASE     = 20'hFFD00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pending,
    input  logic             at_boundary,
    input  logic             long_op,
    input  logic             swi_req,
    input  logic [NUM_W-1:0] swi_num,
    input  logic [DW-1:0]    flg_in,
    input  logic [AW-1:0]    pc_in,
    input  logic [DW-1:0]    isp_in,
    input  logic [DW-1:0]    usp_in,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic             bus_rdy,
    input  logic [DW-1:0]    bus_rdata,
    output logic             busy,
    output logic             suspended,
    output logic             irq_clr,
    output logic [NUM_W-1:0] irq_clr_num,
    output logic             flg_we,
    output logic [DW-1:0]    flg_wdata,
    output logic             sp_we,
    output logic             sp_sel,
    output logic [DW-1:0]    sp_wdata,
    output logic             pc_we,
    output logic [AW-1:0]    pc_wdata
);
    localparam int unsigned PCHI_W = AW - DW;

    entry_state_t     state;
    logic             go, start, step_done, commit;
    logic             use_usp;
    logic             is_swi_q, mid_q, usp_sel_q, clr_q;
    logic [NUM_W-1:0] num_q;
    logic [LVL_W-1:0] lvl_q;
    logic [DW-1:0]    flg_q, sp_q, vlo_q;
    logic [AW-1:0]    pc_q;
    logic [PCHI_W-1:0] vhi_q;
    logic [DW-1:0]    save_word;
    logic [DW-1:0]    flg_new;

    // Entry qualification: software request wins over hardware
    always_comb begin
        go      = swi_req || (irq_pending && (at_boundary || long_op));
        start   = (state == ST_IDLE) && go;
        use_usp = swi_req && (swi_num >= NUM_W'(SWI_KEEP_MIN)) && flg_in[FLG_U];
    end

    irq_entry_fsm #(
        .ENTRY_CYCLES (ENTRY_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .bus_rdy   (bus_rdy),
        .state     (state),
        .busy      (busy),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .step_done (step_done),
        .commit    (commit)
    );

    // Latched context for the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_swi_q  <= 1'b0;
            mid_q     <= 1'b0;
            usp_sel_q <= 1'b0;
            clr_q     <= 1'b0;
            num_q     <= '0;
            lvl_q     <= '0;
            flg_q     <= '0;
            sp_q      <= '0;
            pc_q      <= '0;
            vlo_q     <= '0;
            vhi_q     <= '0;
        end else begin
            clr_q <= 1'b0;
            if (start) begin
                is_swi_q  <= swi_req;
                mid_q     <= !swi_req && !at_boundary;
                usp_sel_q <= use_usp;
                num_q     <= swi_req ? swi_num : '0;
                flg_q     <= flg_in;
                pc_q      <= pc_in;
                sp_q      <= use_usp ? usp_in : isp_in;
            end
            if (step_done) begin
                unique case (state)
                    ST_ACK: begin
                        if (!is_swi_q) begin
                            num_q <= bus_rdata[ACK_NUM_LSB +: NUM_W];
                            lvl_q <= bus_rdata[ACK_LVL_LSB +: LVL_W];
                            clr_q <= 1'b1;
                        end
                    end
                    ST_VLO:  vlo_q <= bus_rdata;
                    ST_VHI:  vhi_q <= bus_rdata[PCHI_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Pushed flag word carries the return address high bits
    always_comb begin
        save_word = flg_q;
        save_word[PCHI_LSB +: PCHI_W] = pc_q[AW-1:DW];
    end

    irq_entry_addr #(
        .AW       (AW),
        .DW       (DW),
        .VEC_BASE (VEC_BASE)
    ) u_addr (
        .state     (state),
        .sp_base   (sp_q),
        .vec_num   (num_q),
        .save_word (save_word),
        .pc_lo     (pc_q[DW-1:0]),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    irq_entry_flags #(
        .DW (DW)
    ) u_flags (
        .flg_copy (flg_q),
        .is_swi   (is_swi_q),
        .num      (num_q),
        .level    (lvl_q),
        .flg_new  (flg_new)
    );

    // Core-facing outputs
    always_comb begin
        suspended   = busy && mid_q;
        irq_clr     = clr_q;
        irq_clr_num = num_q;
        flg_we      = commit;
        flg_wdata   = flg_new;
        sp_we       = commit;
        sp_sel      = usp_sel_q;
        sp_wdata    = sp_q - DW'(4);
        pc_we       = commit;
        pc_wdata    = {vhi_q, vlo_q};
    end

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int unsigned AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_pending,
    input logic          at_boundary,
    input logic          long_op,
    input logic          swi_req,
    input logic          busy,
    input logic          bus_req,
    input logic          bus_rdy,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          irq_clr,
    input logic          pc_we
);
    // R1: a sequence starts only after a qualified request
    a_r1_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(swi_req || (irq_pending && (at_boundary || long_op))));

    // R12: bus requests only while busy
    a_r12_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    // R12: an access holds until ready
    a_r12_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R10: commit ends the sequence
    a_r10_commit_ends: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> !busy);

    // R4: clear pulse is a single cycle inside the sequence
    a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |-> busy ##1 !irq_clr);

endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pending (irq_pending),
    .at_boundary (at_boundary),
    .long_op     (long_op),
    .swi_req     (swi_req),
    .busy        (busy),
    .bus_req     (bus_req),
    .bus_rdy     (bus_rdy),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .irq_clr     (irq_clr),
    .pc_we       (pc_we)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

    localparam logic [19:0] VB = 20'hFFD00;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_pending, at_boundary, long_op, swi_req;
    logic [5:0]  swi_num;
    logic [15:0] flg_in, isp_in, usp_in;
    logic [19:0] pc_in;
    logic        bus_req, bus_we, bus_rdy;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        busy, suspended, irq_clr, flg_we, sp_we, sp_sel, pc_we;
    logic [5:0]  irq_clr_num;
    logic [15:0] flg_wdata, sp_wdata;
    logic [19:0] pc_wdata;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .at_boundary(at_boundary),
        .long_op(long_op), .swi_req(swi_req), .swi_num(swi_num), .flg_in(flg_in),
        .pc_in(pc_in), .isp_in(isp_in), .usp_in(usp_in), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
        .bus_rdata(bus_rdata), .busy(busy), .suspended(suspended), .irq_clr(irq_clr),
        .irq_clr_num(irq_clr_num), .flg_we(flg_we), .flg_wdata(flg_wdata), .sp_we(sp_we),
        .sp_sel(sp_sel), .sp_wdata(sp_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
    );

    // Bus responder with programmable wait states
    int          waits = 0;
    int          wcnt  = 0;
    logic [15:0] ack_word = '0;

    always @(posedge clk) begin
        if (bus_req && !bus_rdy) wcnt <= wcnt + 1;
        else                     wcnt <= 0;
    end

    assign bus_rdy = bus_req && (wcnt >= waits);

    always_comb begin
        if (bus_addr == 20'h0)  bus_rdata = ack_word;
        else if (!bus_addr[1])  bus_rdata = bus_addr[15:0] ^ 16'hA5A5;
        else                    bus_rdata = {12'h0, bus_addr[5:2]};
    end

    // Observation recorder
    int          busy_cnt, clr_cnt, pcwe_cnt, acc_n, req_cnt;
    bit          susp_seen;
    logic [5:0]  clr_num;
    logic [19:0] acc_addr [8];
    logic        acc_we   [8];
    logic [15:0] acc_wd   [8];
    logic [19:0] got_pc;
    logic [15:0] got_sp, got_flg;
    logic        got_sel, got_spwe, got_flgwe;

    always @(negedge clk) begin
        if (busy)      busy_cnt++;
        if (bus_req)   req_cnt++;
        if (suspended) susp_seen = 1'b1;
        if (irq_clr) begin
            clr_cnt++;
            clr_num = irq_clr_num;
        end
        if (bus_req && bus_rdy) begin
            if (acc_n < 8) begin
                acc_addr[acc_n] = bus_addr;
                acc_we[acc_n]   = bus_we;
                acc_wd[acc_n]   = bus_wdata;
            end
            acc_n++;
        end
        if (pc_we) begin
            pcwe_cnt++;
            got_pc    = pc_wdata;
            got_sp    = sp_wdata;
            got_sel   = sp_sel;
            got_flg   = flg_wdata;
            got_spwe  = sp_we;
            got_flgwe = flg_we;
        end
    end

    task automatic clear_rec();
        busy_cnt = 0; clr_cnt = 0; pcwe_cnt = 0; acc_n = 0; req_cnt = 0;
        susp_seen = 1'b0; clr_num = '0;
        got_pc = '0; got_sp = '0; got_flg = '0; got_sel = 1'b0;
        got_spwe = 1'b0; got_flgwe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            acc_addr[i] = '0; acc_we[i] = 1'b0; acc_wd[i] = '0;
        end
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle_inputs();
        irq_pending = 1'b0; at_boundary = 1'b0; long_op = 1'b0; swi_req = 1'b0;
    endtask

    // Runs one entry and checks every observable result
    task automatic do_entry(input string tag, input bit hw, input bit sw,
                            input logic [5:0] hnum, input logic [2:0] lvl,
                            input logic [5:0] snum, input logic [15:0] flg,
                            input logic [19:0] pc, input logic [15:0] isp,
                            input logic [15:0] usp, input bit bnd, input bit lop,
                            input int w);
        logic [5:0]  n;
        bit          keep_u, uu;
        logic [15:0] base, fexp, save;
        logic [19:0] vec, pexp;
        int          exp_busy, guard;
        @(negedge clk);
        clear_rec();
        waits       = w;
        ack_word    = {1'b0, lvl, 6'b0, hnum};
        irq_pending = hw; at_boundary = bnd; long_op = lop;
        swi_req     = sw; swi_num = snum;
        flg_in = flg; pc_in = pc; isp_in = isp; usp_in = usp;
        @(negedge clk);
        idle_inputs();
        guard = 0;
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);

        n        = sw ? snum : hnum;
        keep_u   = sw && (snum >= 6'd32);
        uu       = keep_u && flg[7];
        base     = uu ? usp : isp;
        vec      = VB + {12'h0, n, 2'b00};
        pexp     = {(vec[5:2]), vec[15:0] ^ 16'hA5A5};
        save     = {flg[15:12], pc[19:16], flg[7:0]};
        fexp     = flg;
        fexp[6]  = 1'b0;
        fexp[1]  = 1'b0;
        if (!keep_u) fexp[7] = 1'b0;
        if (!sw) fexp[14:12] = lvl;
        exp_busy = (5 * w + 6 >= 17) ? 5 * w + 7 : 18;

        chk({"R12 busy length ", tag}, busy_cnt, exp_busy);
        chk({"R2 suspended ", tag}, susp_seen, (!sw && !bnd));
        chk({"R3 access count ", tag}, acc_n, 5);
        chk({"R3 ack addr ", tag}, acc_addr[0], 0);
        chk({"R3 ack is read ", tag}, acc_we[0], 0);
        chk({"R5 flag push addr ", tag}, acc_addr[1], {4'h0, base - 16'd2});
        chk({"R5 flag push data ", tag}, {acc_we[1], acc_wd[1]}, {1'b1, save});
        chk({"R5 pc push addr ", tag}, acc_addr[2], {4'h0, base - 16'd4});
        chk({"R5 pc push data ", tag}, {acc_we[2], acc_wd[2]}, {1'b1, pc[15:0]});
        chk({"R6 vec low addr ", tag}, acc_addr[3], vec);
        chk({"R6 vec high addr ", tag}, acc_addr[4], vec + 20'd2);
        chk({"R4 clear count ", tag}, clr_cnt, sw ? 0 : 1);
        if (!sw) chk({"R4 clear number ", tag}, clr_num, hnum);
        chk({"R7 flag bits ", tag}, got_flg & 16'h8F7F, fexp & 16'h8F7F);
        chk({"R8 stack select bit ", tag}, got_flg[7], fexp[7]);
        chk({"R9 level field ", tag}, got_flg[14:12], fexp[14:12]);
        chk({"R10 pc write count ", tag}, pcwe_cnt, 1);
        chk({"R10 pc value ", tag}, got_pc, pexp);
        chk({"R11 sp value ", tag}, {got_spwe, got_flgwe, got_sp}, {2'b11, base - 16'd4});
        chk({"R8 sp select ", tag}, got_sel, uu);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 reset busy", busy, 0);
        chk("R12 reset bus_req", bus_req, 0);
        chk("R10 reset pc_we", pc_we, 0);
        chk("R4 reset irq_clr", irq_clr, 0);
    endtask

    task automatic t_unqualified();
        @(negedge clk);
        clear_rec();
        irq_pending = 1'b1;
        repeat (6) @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk("R1 unqualified busy", busy_cnt, 0);
        chk("R1 unqualified bus", req_cnt, 0);
    endtask

    task automatic t_hw_boundary();
        do_entry("hw boundary", 1, 0, 6'd17, 3'd5, 6'd0, 16'hF0C7, 20'hA1234,
                 16'h0800, 16'h4000, 1, 0, 0);
    endtask

    task automatic t_hw_long_op();
        do_entry("hw long op", 1, 0, 6'd63, 3'd2, 6'd0, 16'h30CB, 20'h5FFFE,
                 16'h1000, 16'h2000, 0, 1, 0);
    endtask

    task automatic t_swi_keep();
        do_entry("swi 32 keep", 0, 1, 6'd0, 3'd0, 6'd32, 16'h20C2, 20'h3ABCD,
                 16'h0900, 16'h7F00, 1, 0, 0);
    endtask

    task automatic t_swi_clear();
        do_entry("swi 31 clear", 0, 1, 6'd0, 3'd0, 6'd31, 16'h60C2, 20'h0C0DE,
                 16'h0900, 16'h7F00, 1, 0, 0);
    endtask

    task automatic t_hw_waits();
        do_entry("hw waits", 1, 0, 6'd9, 3'd7, 6'd0, 16'h0041, 20'hFEDC8,
                 16'h0400, 16'h3000, 1, 0, 3);
        waits = 0;
    endtask

    task automatic t_both();
        do_entry("hw and swi", 1, 1, 6'd5, 3'd6, 6'd50, 16'h1080, 20'h12340,
                 16'h0600, 16'h5000, 1, 0, 0);
        chk("R13 software wins, no clear", clr_cnt, 0);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        swi_num = '0; flg_in = '0; pc_in = '0; isp_in = '0; usp_in = '0;
        clear_rec();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unqualified();
        t_hw_boundary();
        t_hw_long_op();
        t_swi_keep();
        t_swi_clear();
        t_hw_waits();
        t_both();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule